// File: doc/BRIEF.md
# Zero-Cross Gated Fade Controller

This block scales a stream of 24-bit signed audio samples by a gain that moves between mute and unity along a stepped S-shaped curve. A fade-in or fade-out request starts the ramp. The gain moves one step at a time, and a step is taken only on a sample where the signal crosses zero. Because the gain changes where the waveform is near zero, the change in level causes no audible click.

A signal that stops crossing zero would stall the ramp. To prevent this, a timeout counts strobed samples without a crossing. When it expires, the remaining steps are taken one per sample. An abort input mutes the output at once and drops any fade in progress. A later fade-in then starts from mute.

The block sits in the sample path after a decimator and before the serial output formatter. It runs on the sample-valid strobe and adds one register stage of latency.

Top module: `fade_ctrl`

## Requirements
- R1: After reset, `smp_o` is 0, `smp_vld_o`, `busy_o` and `done_o` are low, and the gain index is 0 (mute).
- R2: There are 49 gain levels, k = 0..48, as unsigned Q1.15 values. For k <= 24, g(k) = floor(32768*k*k*(144-2k)/110592). For k > 24, g(k) = 32768 - g(48-k). So g(0) = 0, g(24) = 16384 and g(48) = 32768.
- R3: A strobe is a zero crossing when its sample equals 0, or when its sign bit differs from the sign bit of the previous strobed sample. The previous sign is taken as non-negative after reset. While a fade is active, the index moves one step only on a crossing strobe.
- R4: On the clock edge that takes a strobe, `smp_o` is loaded with clamp24((s*g + 16384) >>> 15), where g is the gain of the index held before that edge. `smp_vld_o` follows `smp_vld_i` by one cycle, and `smp_o` holds its value between strobes.
- R5: `fade_in_i` sets the direction upward and `fade_out_i` sets it downward. If both are high, `fade_out_i` wins. A strobe in the same cycle as a request takes no step.
- R6: The step that reaches index 48 or index 0 clears `busy_o`, and `done_o` goes high for exactly one cycle on that same edge. At index 48, `smp_o` equals the input sample.
- R7: While a fade is active, 8192 consecutive strobes without a crossing put the fade into forced mode. From then on every strobe takes a step until the fade ends.
- R8: A request in the opposite direction, made during a fade, reverses the ramp from the current index without any jump.
- R9: `abort_i` forces the index to 0, clears `busy_o`, and sets `smp_o` to 0 on that edge. It overrides both requests.
- R10: A fade-in at index 48, or a fade-out at index 0, leaves `busy_o` low and produces no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_i | input | 24 | Signed input sample |
| smp_vld_i | input | 1 | Input sample strobe |
| fade_in_i | input | 1 | Request a ramp toward unity |
| fade_out_i | input | 1 | Request a ramp toward mute |
| abort_i | input | 1 | Immediate mute, cancels any fade |
| smp_o | output | 24 | Scaled signed sample |
| smp_vld_o | output | 1 | Output sample strobe |
| busy_o | output | 1 | A fade is in progress |
| done_o | output | 1 | One-cycle pulse when a fade completes |

## Verification
A wrong gain index shows up on the first strobe after it goes wrong, because every scaled sample depends on the index held before that strobe. The reference model therefore catches a missed or extra step one cycle after the edge that caused it. A lost zero-crossing decision or a miscounted timeout shows up as a step taken on the wrong strobe. It can also show up as `busy_o` falling on the wrong cycle. A bad ROM entry shows up only on samples scaled at that level, so the test ramps run through every index with non-zero data.

// File: rtl/fade_pkg.sv
package fade_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } fade_dir_e;

  typedef struct packed {
    logic go;
    fade_dir_e dir;
  } fade_req_t;
endpackage

// File: rtl/fade_gain_rom.sv
module fade_gain_rom #(
  parameter int STEPS  = 48,
  parameter int COEF_W = 16,
  parameter int IDX_W  = $clog2(STEPS + 1)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [COEF_W-1:0] gain_o
);
  localparam longint UNITY = longint'(1) << (COEF_W - 1);
  localparam int     HALF  = STEPS / 2;

  // smoothstep on the lower half, mirrored for the upper half
  function automatic logic [COEF_W-1:0] curve(input int k);
    longint n, kk, v;
    n  = longint'(STEPS);
    kk = (k <= HALF) ? longint'(k) : longint'(STEPS - k);
    v  = (UNITY * kk * kk * (3 * n - 2 * kk)) / (n * n * n);
    return (k <= HALF) ? COEF_W'(v) : COEF_W'(UNITY - v);
  endfunction

  logic [COEF_W-1:0] table_w [STEPS+1];

  for (genvar k = 0; k <= STEPS; k++) begin : g_rom
    assign table_w[k] = curve(k);
  end

  assign gain_o = (32'(idx_i) <= STEPS) ? table_w[idx_i] : '0;
endmodule

// File: rtl/fade_zc_detect.sv
module fade_zc_detect #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              vld_i,
  output logic              zc_o
);
  logic prev_neg_q;

  assign zc_o = vld_i && ((smp_i == '0) || (smp_i[DATA_W-1] != prev_neg_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_neg_q <= 1'b0;
    else if (vld_i) prev_neg_q <= smp_i[DATA_W-1];
  end
endmodule

// File: rtl/fade_step_ctrl.sv
module fade_step_ctrl
  import fade_pkg::*;
#(
  parameter int STEPS   = 48,
  parameter int TIMEOUT = 8192,
  parameter int IDX_W   = $clog2(STEPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             zc_i,
  input  logic             fade_in_i,
  input  logic             fade_out_i,
  input  logic             abort_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int                CNT_W    = $clog2(TIMEOUT + 1);
  localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(STEPS);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [IDX_W-1:0] idx_q, idx_nx;
  fade_dir_e        dir_q;
  logic             active_q, forced_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step_en, at_end;
  fade_req_t        req;

  always_comb begin
    req.go  = fade_in_i || fade_out_i;
    req.dir = fade_out_i ? DIR_DOWN : DIR_UP;
  end

  always_comb begin
    step_en = vld_i && active_q && (zc_i || forced_q);
    idx_nx  = (dir_q == DIR_UP) ? idx_q + 1'b1 : idx_q - 1'b1;
    at_end  = (dir_q == DIR_UP) ? (idx_nx == IDX_TOP) : (idx_nx == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      dir_q    <= DIR_UP;
      active_q <= 1'b0;
      forced_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        idx_q    <= '0;
        active_q <= 1'b0;
        forced_q <= 1'b0;
        cnt_q    <= '0;
      end else if (req.go) begin
        dir_q    <= req.dir;
        active_q <= (req.dir == DIR_UP) ? (idx_q != IDX_TOP) : (idx_q != '0);
        forced_q <= 1'b0;
        cnt_q    <= '0;
      end else if (vld_i && active_q) begin
        if (step_en) begin
          idx_q <= idx_nx;
          if (at_end) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
        if (zc_i) begin
          cnt_q <= '0;
        end else if (!forced_q) begin
          if (cnt_q == CNT_LAST) forced_q <= 1'b1;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = active_q;
  assign done_o = done_q;
endmodule

// File: rtl/fade_scaler.sv
module fade_scaler #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              vld_i,
  input  logic              abort_i,
  input  logic [COEF_W-1:0] gain_i,
  output logic [DATA_W-1:0] smp_o,
  output logic              vld_o
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int FRAC   = COEF_W - 1;
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (FRAC - 1);
  localparam logic signed [PROD_W-1:0] POS_MAX  = PROD_W'((longint'(1) << (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] NEG_MIN  = -(PROD_W'(longint'(1) << (DATA_W - 1)));

  logic signed [PROD_W-1:0] prod, shifted;
  logic        [DATA_W-1:0] clamped;

  always_comb begin
    prod    = PROD_W'($signed(smp_i)) * $signed({1'b0, gain_i});
    shifted = (prod + HALF_LSB) >>> FRAC;
    if (shifted > POS_MAX)      clamped = POS_MAX[DATA_W-1:0];
    else if (shifted < NEG_MIN) clamped = NEG_MIN[DATA_W-1:0];
    else                        clamped = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (abort_i)    smp_o <= '0;
      else if (vld_i) smp_o <= clamped;
    end
  end
endmodule

// File: rtl/fade_ctrl.sv
module fade_ctrl #(
  parameter int DATA_W  = 24,
  parameter int COEF_W  = 16,
  parameter int STEPS   = 48,
  parameter int TIMEOUT = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              smp_vld_i,
  input  logic              fade_in_i,
  input  logic              fade_out_i,
  input  logic              abort_i,
  output logic [DATA_W-1:0] smp_o,
  output logic              smp_vld_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int IDX_W = $clog2(STEPS + 1);

  logic             zc_w;
  logic [IDX_W-1:0] idx_w;
  logic [COEF_W-1:0] gain_w;

  fade_zc_detect #(.DATA_W(DATA_W)) u_zc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp_i),
    .vld_i (smp_vld_i),
    .zc_o  (zc_w)
  );

  fade_step_ctrl #(.STEPS(STEPS), .TIMEOUT(TIMEOUT), .IDX_W(IDX_W)) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (smp_vld_i),
    .zc_i      (zc_w),
    .fade_in_i (fade_in_i),
    .fade_out_i(fade_out_i),
    .abort_i   (abort_i),
    .idx_o     (idx_w),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  fade_gain_rom #(.STEPS(STEPS), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_rom (
    .idx_i (idx_w),
    .gain_o(gain_w)
  );

  fade_scaler #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp_i),
    .vld_i  (smp_vld_i),
    .abort_i(abort_i),
    .gain_i (gain_w),
    .smp_o  (smp_o),
    .vld_o  (smp_vld_o)
  );
endmodule

// File: rtl/fade_ctrl_chk.sv
module fade_ctrl_chk #(
  parameter int DATA_W = 24,
  parameter int STEPS  = 48,
  parameter int IDX_W  = $clog2(STEPS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] smp_i,
  input logic              smp_vld_i,
  input logic              fade_in_i,
  input logic              fade_out_i,
  input logic              abort_i,
  input logic [DATA_W-1:0] smp_o,
  input logic              smp_vld_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [IDX_W-1:0]  idx_i
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(STEPS);

  p_vld_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |=> smp_vld_o);
  p_vld_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> !smp_vld_o);
  p_mute_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == '0 && smp_vld_i) |=> (smp_o == '0));
  p_unity_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == IDX_TOP && smp_vld_i && !abort_i) |=> (smp_o == $past(smp_i)));
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_single_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_i |=> (idx_i == $past(idx_i) || idx_i == $past(idx_i) + 1'b1
                  || idx_i + 1'b1 == $past(idx_i)));
  p_abort_mute_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (smp_o == '0 && !busy_o && idx_i == '0));
  p_idle_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fade_out_i && !abort_i && idx_i == '0) |=> !busy_o);
  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idx_i) <= STEPS);
endmodule

bind fade_ctrl fade_ctrl_chk #(.DATA_W(DATA_W), .STEPS(STEPS), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_i     (smp_i),
  .smp_vld_i (smp_vld_i),
  .fade_in_i (fade_in_i),
  .fade_out_i(fade_out_i),
  .abort_i   (abort_i),
  .smp_o     (smp_o),
  .smp_vld_o (smp_vld_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .idx_i     (idx_w)
);

// File: tb/tb_fade_ctrl.sv
`timescale 1ns/1ps
module tb_fade_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] smp = '0;
  logic        vld = 1'b0, f_in = 1'b0, f_out = 1'b0, abrt = 1'b0;
  logic [23:0] smp_o;
  logic        vld_o, busy_o, done_o;

  int checks = 0, fails = 0, cyc = 0, done_seen = 0;
  string phase = "R1";
  bit finished = 0;

  // reference state
  int m_idx = 0, m_dir = 1, m_act = 0, m_forced = 0, m_cnt = 0, m_prevneg = 0;
  int e_out = 0, e_vld = 0, e_done = 0;

  always #2.5 clk = ~clk;

  fade_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_vld_i(vld),
    .fade_in_i(f_in), .fade_out_i(f_out), .abort_i(abrt),
    .smp_o(smp_o), .smp_vld_o(vld_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic longint gain_of(int k);
    longint kk, v;
    kk = (k <= 24) ? k : 48 - k;
    v  = 32768 * kk * kk * (144 - 2 * kk) / 110592;
    return (k <= 24) ? v : 32768 - v;
  endfunction

  function automatic int scale(int s, longint g);
    longint p;
    p = (longint'(s) * g + 16384) >>> 15;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return int'(p);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_dir = 1; m_act = 0; m_forced = 0; m_cnt = 0; m_prevneg = 0;
      e_out = 0; e_vld = 0; e_done = 0;
    end else begin
      int s, neg, zc;
      s   = $signed(smp);
      neg = (s < 0);
      zc  = vld && (s == 0 || neg != m_prevneg);
      if (abrt) e_out = 0;
      else if (vld) e_out = scale(s, gain_of(m_idx));
      e_vld  = vld;
      e_done = 0;
      if (vld) m_prevneg = neg;
      if (abrt) begin
        m_idx = 0; m_act = 0; m_forced = 0; m_cnt = 0;
      end else if (f_out || f_in) begin
        m_dir = f_out ? 0 : 1;
        m_act = m_dir ? (m_idx != 48) : (m_idx != 0);
        m_forced = 0; m_cnt = 0;
      end else if (vld && m_act) begin
        if (zc || m_forced) begin
          m_idx += m_dir ? 1 : -1;
          if (m_idx == 0 || m_idx == 48) begin m_act = 0; e_done = 1; end
        end
        if (zc) m_cnt = 0;
        else if (!m_forced) begin
          if (m_cnt == 8191) m_forced = 1;
          m_cnt++;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk($signed(smp_o) == e_out, {phase, " data"}, $signed(smp_o), e_out);
      chk({vld_o, busy_o, done_o} == {e_vld[0], m_act[0], e_done[0]}, {phase, " flags"},
          {vld_o, busy_o, done_o}, {e_vld[0], m_act[0], e_done[0]});
      if (done_o) done_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic drive(bit v, int s, bit fi = 0, bit fo = 0, bit ab = 0);
    @(negedge clk);
    vld = v; smp = 24'(s); f_in = fi; f_out = fo; abrt = ab;
  endtask

  task automatic tri_wave(int n);
    int pat [6] = '{1000000, 3000000, 1000000, -1000000, -3000000, -1000000};
    for (int i = 0; i < n; i++) drive(1, pat[i % 6]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_o == 0 && !vld_o && !busy_o && !done_o, "R1 reset", {smp_o, vld_o, busy_o, done_o}, 0);

    phase = "R10";
    drive(0, 0, 0, 1);
    drive(0, 0);
    chk(!busy_o, "R10 fade-out at mute", busy_o, 0);

    phase = "R5 R3 R2";
    done_seen = 0;
    drive(0, 0, 1, 0);
    tri_wave(200);
    drive(0, 0);
    chk(!busy_o && done_seen == 1, "R6 fade-in completes", done_seen, 1);

    phase = "R6 R4";
    drive(1, 8388607); drive(1, -8388608); drive(1, -1); drive(1, 1); drive(1, 0);
    drive(0, 0);
    chk($signed(smp_o) == 0, "R4 hold", $signed(smp_o), 0);

    phase = "R10";
    drive(0, 0, 1, 0);
    drive(0, 0);
    chk(!busy_o && !done_o, "R10 fade-in at unity", busy_o, 0);

    phase = "R3 zero";
    done_seen = 0;
    drive(0, 0, 0, 1);
    for (int i = 0; i < 300; i++) drive(1, (i % 5 == 4) ? 0 : 777777 + i);
    drive(0, 0);
    chk(!busy_o && done_seen == 1, "R3 zeros step fade-out", done_seen, 1);

    phase = "R7";
    done_seen = 0;
    drive(0, 0, 1, 0);
    for (int i = 0; i < 8192 + 60; i++) drive(1, 5000000);
    drive(0, 0);
    chk(!busy_o && done_seen == 1, "R7 forced fade-in", done_seen, 1);

    phase = "R8";
    done_seen = 0;
    drive(0, 0, 0, 1);
    tri_wave(60);
    chk(busy_o, "R8 mid fade", busy_o, 1);
    drive(0, 0, 1, 0);
    tri_wave(200);
    drive(0, 0);
    chk(!busy_o && done_seen == 1, "R8 reversed to unity", done_seen, 1);

    phase = "R5 both";
    drive(1, 1000, 1, 1);
    tri_wave(40);
    chk(busy_o, "R5 fade-out wins", busy_o, 1);

    phase = "R9";
    drive(1, 4000000, 1, 0, 1);
    drive(0, 0);
    chk(smp_o == 0 && !busy_o, "R9 abort mutes", $signed(smp_o), 0);
    done_seen = 0;
    drive(0, 0, 1, 0);
    tri_wave(200);
    drive(0, 0);
    chk(!busy_o && done_seen == 1, "R9 fade-in after abort", done_seen, 1);

    drive(0, 0);
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule